// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block arbitrates eight interrupt inputs in the classic PC style. It holds three 8-bit registers: pending requests, levels in service and masked inputs. It drives one interrupt line to the processor. When the processor acknowledges, the block returns a vector. The vector is a programmed base with the winning level number in its low three bits.

Software reaches the block through a two-address register port. Address 0 takes commands and returns status. Address 1 takes mask and setup data and returns the mask.

A command with bit 4 set starts a staged setup sequence, and the data writes that follow it load the vector base, the cascade byte and, when requested, the mode byte. After setup, commands end service for one level or for the highest level, and choose which register address 0 returns.

Each input is captured on its rising edge or by its level, as chosen by an external select bit. Automatic end-of-service mode is available. An acknowledge with nothing to grant reports level 7 as spurious.

Top module: `pic_core`

## Requirements
- R1: After reset, the pending, in-service and mask registers are all zero. Address 0 returns the pending register, and `int_out` is low.
- R2: A write to address 0 with bit 4 set starts setup and clears the mask, pending and in-service registers. The following data writes load the vector base (bits 7:3), then the cascade byte (shown on `cascade_cfg`), then the mode byte. The mode byte is expected only when bit 0 of the starting command was 1.
- R3: A data write outside setup loads the mask register (bit n = 1 masks input n). A value of 0xFF stops every request from reaching `int_out`, although masked requests still appear in the pending register.
- R4: A command of 0x0A makes address 0 return the pending register, and 0x0B makes it return the in-service register. Address 1 always returns the mask register.
- R5: Input 0 has the highest priority. On an acknowledge pulse (`inta`) while `int_out` is high, the lowest-numbered unmasked pending level is granted. Its pending bit clears, its in-service bit sets, and `vec_out` shows {base, level} from the next cycle.
- R6: A pending request raises `int_out` only when no level of equal or higher priority is in service.
- R7: A command of 0x60+n (n in 0..7) clears in-service bit n only. A command of 0x20 clears the highest-priority in-service bit.
- R8: If bit 1 of the mode byte is 1, a grant leaves the in-service register unchanged.
- R9: An acknowledge while `int_out` is low is spurious. It returns {base, 7} on `vec_out` and sets no in-service bit, even when input 7 is masked.
- R10: When `trig_level[n]` is 0, input n is edge-triggered: a rising edge sets pending bit n, and the bit stays set after the input falls. When `trig_level[n]` is 1, pending bit n follows the input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = command/status, 1 = mask/data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Interrupt inputs |
| trig_level | input | 8 | Per-input trigger select, 1 = level |
| inta | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt request to processor |
| vec_out | output | 8 | Vector from the last acknowledge |
| cascade_cfg | output | 8 | Cascade byte from setup |

## Verification
On every cycle, the assertions check these invariants:
- setup empties all three registers;
- a grant adds an in-service bit unless automatic end-of-service is on;
- automatic mode keeps the in-service register empty;
- a spurious acknowledge adds no in-service bit and returns level 7.

Only the bench scenarios can show the rest. These include priority order between simultaneous requests and nesting of a higher request over a lower one in service. They also include the vector values, readback selection, masking, and the difference between edge and level capture.

// File: rtl/pic_core.sv
module pic_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] irq_in,
  input  logic [7:0] trig_level,
  input  logic       inta,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic [7:0] cascade_cfg
);
  typedef enum logic [1:0] {S_RUN, S_W2, S_W3, S_W4} st_t;
  st_t st;

  logic [7:0] irr, isr, imr, irq_d, irr_nxt, isr_nxt;
  logic [4:0] base;
  logic       need4, aeoi, rd_isr;

  wire cmd_wr = reg_wr & ~reg_addr;
  wire dat_wr = reg_wr & reg_addr;
  wire start  = cmd_wr & reg_wdata[4];
  wire ocw2   = cmd_wr & ~reg_wdata[4] & ~reg_wdata[3];
  wire [7:0] pend = irr & ~imr;

  function automatic logic [3:0] top(input logic [7:0] v);
    top = 4'b1000;
    for (int i = 7; i >= 0; i--)
      if (v[i]) top = {1'b0, 3'(i)};
  endfunction

  wire [3:0] pw = top(pend);
  wire [3:0] sw = top(isr);

  assign int_out = (st == S_RUN) && !pw[3] && (sw[3] || pw[2:0] < sw[2:0]);
  wire grant = inta & int_out;

  always_comb begin
    for (int i = 0; i < 8; i++)
      irr_nxt[i] = trig_level[i] ? irq_in[i] : (irr[i] | (irq_in[i] & ~irq_d[i]));
    if (grant) irr_nxt[pw[2:0]] = 1'b0;
    if (start) irr_nxt = 8'h00;
  end

  always_comb begin
    isr_nxt = isr;
    if (grant && !aeoi) isr_nxt[pw[2:0]] = 1'b1;
    if (ocw2) begin
      if (reg_wdata[7:5] == 3'b011) isr_nxt[reg_wdata[2:0]] = 1'b0;
      else if (reg_wdata[7:5] == 3'b001 && !sw[3]) isr_nxt[sw[2:0]] = 1'b0;
    end
    if (start) isr_nxt = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN; irr <= '0; isr <= '0; imr <= '0; irq_d <= '0;
      base <= '0; need4 <= 1'b0; aeoi <= 1'b0; rd_isr <= 1'b0;
      vec_out <= '0; cascade_cfg <= '0;
    end else begin
      irr   <= irr_nxt;
      isr   <= isr_nxt;
      irq_d <= irq_in;
      if (inta) vec_out <= {base, grant ? pw[2:0] : 3'd7};
      if (start) begin
        imr <= '0; rd_isr <= 1'b0; aeoi <= 1'b0;
        need4 <= reg_wdata[0]; st <= S_W2;
      end else if (dat_wr) begin
        case (st)
          S_RUN: imr <= reg_wdata;
          S_W2:  begin base <= reg_wdata[7:3]; st <= S_W3; end
          S_W3:  begin cascade_cfg <= reg_wdata; st <= need4 ? S_W4 : S_RUN; end
          default: begin aeoi <= reg_wdata[1]; st <= S_RUN; end
        endcase
      end else if (cmd_wr && reg_wdata[3] && reg_wdata[1]) begin
        rd_isr <= reg_wdata[0];
      end
    end
  end

  assign reg_rdata = reg_addr ? imr : (rd_isr ? isr : irr);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (irr == 8'h00 && isr == 8'h00 && imr == 8'h00)); // R2
  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !aeoi && !reg_wr) |=> ((isr & ~$past(isr)) != 8'h00)); // R5
  AST_AEOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi |-> isr == 8'h00); // R8
  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |=> ((isr & ~$past(isr)) == 8'h00)); // R9
  AST_SPUR_LEVEL7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |=> vec_out[2:0] == 3'd7); // R9
endmodule

// File: tb/pic_core_test.sv
module pic_core_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0, inta = 0;
  logic [7:0] reg_wdata = 0, irq_in = 0, trig_level = 0;
  logic [7:0] reg_rdata, vec_out, cascade_cfg;
  logic int_out;
  int checks = 0, fails = 0;
  bit done = 0;

  pic_core uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .trig_level(trig_level), .inta(inta), .int_out(int_out),
    .vec_out(vec_out), .cascade_cfg(cascade_cfg));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ack();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic setirq(int n, logic v);
    @(negedge clk); irq_in[n] = v;
    @(negedge clk);
  endtask

  task automatic setup(logic [7:0] b, logic [7:0] c, logic [7:0] m);
    wr(0, 8'h11); wr(1, b); wr(1, c); wr(1, m);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 irr", d, 8'h00);
    rd(1, d); chk("R1 imr", d, 8'h00);
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    setup(8'h20, 8'h04, 8'h01);
    chk("R2 cascade", cascade_cfg, 8'h04);
    rd(1, d); chk("R2 imr", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk); irq_in[5] = 1; irq_in[3] = 1; @(negedge clk);
    irq_in = 0;
    chk("R5 int", {7'b0, int_out}, 8'h01);
    wr(0, 8'h0A); rd(0, d); chk("R4 irr", d, 8'h28);
    ack(); chk("R5 vec", vec_out, 8'h23);
    wr(0, 8'h0B); rd(0, d); chk("R4 isr", d, 8'h08);
    wr(0, 8'h0A); rd(0, d); chk("R5 irr cleared", d, 8'h20);
    chk("R6 blocked", {7'b0, int_out}, 8'h00);
    wr(0, 8'h63); chk("R7 specific", {7'b0, int_out}, 8'h01);
    ack(); chk("R5 vec5", vec_out, 8'h25);
    setirq(1, 1); irq_in[1] = 0;
    chk("R6 nest", {7'b0, int_out}, 8'h01);
    ack(); chk("R6 vec1", vec_out, 8'h21);
    wr(0, 8'h0B); rd(0, d); chk("R6 isr", d, 8'h22);
    wr(0, 8'h20); rd(0, d); chk("R7 nonspecific", d, 8'h20);
    wr(0, 8'h65); rd(0, d); chk("R7 clear5", d, 8'h00);
    wr(0, 8'h0A);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1, 8'hFF);
    setirq(4, 1); irq_in[4] = 0;
    chk("R3 masked", {7'b0, int_out}, 8'h00);
    rd(0, d); chk("R3 irr", d, 8'h10);
    rd(1, d); chk("R4 imr", d, 8'hFF);
    ack(); chk("R9 vec", vec_out, 8'h27);
    wr(0, 8'h0B); rd(0, d); chk("R9 isr", d, 8'h00);
    wr(0, 8'h0A);
    wr(1, 8'h00); chk("R3 unmask", {7'b0, int_out}, 8'h01);
    ack(); chk("R5 vec4", vec_out, 8'h24);
    wr(0, 8'h64);
  endtask

  task automatic t_trigger();
    logic [7:0] d;
    trig_level[6] = 1;
    setirq(6, 1); rd(0, d); chk("R10 level high", d, 8'h40);
    setirq(6, 0); rd(0, d); chk("R10 level low", d, 8'h00);
    setirq(2, 1); setirq(2, 0); rd(0, d); chk("R10 edge held", d, 8'h04);
  endtask

  task automatic t_aeoi();
    logic [7:0] d;
    setup(8'h40, 8'h02, 8'h03);
    rd(0, d); chk("R2 clears irr", d, 8'h00);
    setirq(0, 1); irq_in[0] = 0;
    ack(); chk("R8 vec", vec_out, 8'h40);
    wr(0, 8'h0B); rd(0, d); chk("R8 isr", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_init(); t_priority(); t_mask(); t_trigger(); t_aeoi();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule